// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside a simple processor core. It chooses which interrupt the core should take next. Each maskable source carries three pieces of state: a pending flag that its event pulse sets, an enable bit, and a priority from 0 to 7. Software writes the enable bit and the priority. Five non-maskable trap inputs sit above all of these at fixed levels from 10 to 14. The block finds the best pending candidate and compares its level with the level the core is running at. When the candidate is strictly higher, the block raises a request that carries its vector number and level.

When the core acknowledges the request, the block saves the current running level on an internal stack and moves the running level to the level of the accepted request. A return strobe restores the saved level. Because of this, handlers can nest: a higher-level source preempts a running handler, and the lower one resumes later. A maskable pending flag stays set until software clears it. A trap flag clears itself when the trap is acknowledged. While either of the two hard traps is pending, a halt output stops the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable bit and every priority field is 0, no flag is pending, `run_level` is 0, and `req_valid` and `halt` are low.
- R2: A pulse on `src_evt[i]` sets `pend_flags[i]` on the next clock whether or not source i is enabled. A disabled source is never requested.
- R3: A maskable source whose priority is 0 is never requested, even when it is pending and enabled.
- R4: `req_valid` is high only when the best candidate's level is strictly greater than `run_level`, and `req_level` gives that level.
- R5: Vector numbers are assigned as follows: trap t gets vector t (t = 0..4), and maskable source i gets vector 5+i. When several candidates share the highest level, the candidate with the smaller vector number wins.
- R6: A maskable pending flag stays set until software clears it through `clr_we`/`clr_idx`. A flag left set is requested again once the running level has dropped back below its priority.
- R7: When a source event and a software clear of the same flag happen in one cycle, the flag ends up set.
- R8: Traps cannot be masked. Their levels are fixed: trap 0 is oscillator failure at level 14, trap 1 is address error at 13, trap 2 is stack error at 12, trap 3 is math error at 11, and trap 4 is DMA conflict at 10. A trap's flag clears when that trap is acknowledged.
- R9: `halt` is high while trap 0 or trap 1 (the hard traps) is pending. The soft traps 2..4 never raise `halt`.
- R10: An `ack` taken while `req_valid` is high pushes the old running level onto the stack, and `run_level` equals the accepted `req_level` from the next cycle.
- R11: A `ret` strobe pops the stack into `run_level`. A `ret` with an empty stack changes nothing. When `ret` and `ack` arrive in the same cycle, `ret` wins and the `ack` is ignored.
- R12: A request at a higher level can be accepted while a handler is running, and returns unwind the levels in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NUM_SRC | Event pulses of the maskable sources |
| trap_evt | input | 5 | Trap event pulses; bit t is trap t |
| cfg_we | input | 1 | Write strobe for the enable bit and priority of one source |
| cfg_idx | input | log2(NUM_SRC) | Source selected by a configuration write |
| cfg_enable | input | 1 | Enable value to write |
| cfg_prio | input | PRIO_W | Priority value to write |
| clr_we | input | 1 | Software clear strobe for one pending flag |
| clr_idx | input | log2(NUM_SRC) | Source whose flag is cleared |
| ack | input | 1 | Core accepts the current request |
| ret | input | 1 | Core returns from a handler |
| req_valid | output | 1 | A request stands above the running level |
| req_vector | output | log2(NUM_SRC+5) | Vector number of the winning candidate |
| req_level | output | 4 | Level of the winning candidate |
| run_level | output | 4 | Level the core is currently running at |
| halt | output | 1 | A hard trap is pending |
| pend_flags | output | NUM_SRC | Pending flags of the maskable sources |

## Verification
A vector table first sets enable and priority masks and pending patterns, and each pattern is chosen to separate one effect. Sources that are pending and enabled at priority zero separate masking from enabling. A disabled source at a nonzero priority shows that enable gates the request even though the flag is set. Two equal priorities reveal which way ties are broken, and different priorities on high and low indices show that level matters more than index. Directed sequences then go through a two-deep nesting and unwind it, issue a return on an empty stack, issue a return and an acknowledge together, apply a clear and an event in the same cycle, and raise soft, hard and simultaneous traps, so that halt, trap levels and trap self-clearing can each be told apart.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_TRAP = 5;
    localparam int NUM_HARD = 2;
    localparam int LVL_W    = 4;
    localparam int TOP_LVL  = 14;

    // Trap t sits at a fixed level, highest first.
    function automatic logic [LVL_W-1:0] trap_level(input int t);
        return LVL_W'(TOP_LVL - t);
    endfunction
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_SRC-1:0]              evt,
    input  logic                            cfg_we,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  logic                            cfg_enable,
    input  logic [PRIO_W-1:0]               cfg_prio,
    input  logic                            clr_we,
    input  logic [IDX_W-1:0]                clr_idx,
    output logic [NUM_SRC-1:0]              pend,
    output logic [NUM_SRC-1:0]              enable,
    output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio
);
    typedef struct packed {
        logic [NUM_SRC-1:0]             pend;
        logic [NUM_SRC-1:0]             en;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (cfg_we) begin
            bank_d.en[cfg_idx]   = cfg_enable;
            bank_d.prio[cfg_idx] = cfg_prio;
        end
        if (clr_we) begin
            bank_d.pend[clr_idx] = 1'b0;
        end
        // An event wins over a clear in the same cycle.
        bank_d.pend = bank_d.pend | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend   = bank_q.pend;
    assign enable = bank_q.en;
    assign prio   = bank_q.prio;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int NUM_VEC = 13,
    parameter int VEC_W   = 4,
    parameter int LVL_W   = 4
) (
    input  logic [NUM_VEC-1:0]             cand_valid,
    input  logic [NUM_VEC-1:0][LVL_W-1:0]  cand_level,
    output logic                           win_valid,
    output logic [VEC_W-1:0]               win_vec,
    output logic [LVL_W-1:0]               win_level
);
    // Scan from the highest vector down; ">=" lets a lower vector take a tie.
    always_comb begin
        win_valid = 1'b0;
        win_vec   = '0;
        win_level = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (cand_valid[i] && (!win_valid || cand_level[i] >= win_level)) begin
                win_valid = 1'b1;
                win_vec   = VEC_W'(i);
                win_level = cand_level[i];
            end
        end
    end
endmodule

// File: rtl/irqc_level_stack.sv
module irqc_level_stack #(
    parameter int DEPTH = 16,
    parameter int LVL_W = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LVL_W-1:0]  new_level,
    input  logic              pop,
    output logic [LVL_W-1:0]  run_level,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] mem;
        logic [CNT_W-1:0]            cnt;
        logic [LVL_W-1:0]            run;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (pop) begin
            if (stk_q.cnt != '0) begin
                stk_d.run = stk_q.mem[PTR_W'(stk_q.cnt - 1'b1)];
                stk_d.cnt = stk_q.cnt - 1'b1;
            end
        end else if (push && stk_q.cnt != CNT_W'(DEPTH)) begin
            stk_d.mem[PTR_W'(stk_q.cnt)] = stk_q.run;
            stk_d.run                    = new_level;
            stk_d.cnt                    = stk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else begin
            stk_q <= stk_d;
        end
    end

    assign run_level = stk_q.run;
    assign count     = stk_q.cnt;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 16,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int NUM_VEC = NUM_TRAP + NUM_SRC,
    localparam int VEC_W   = $clog2(NUM_VEC),
    localparam int CNT_W   = $clog2(STACK_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_evt,
    input  logic [NUM_TRAP-1:0]  trap_evt,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_enable,
    input  logic [PRIO_W-1:0]    cfg_prio,
    input  logic                 clr_we,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 ack,
    input  logic                 ret,
    output logic                 req_valid,
    output logic [VEC_W-1:0]     req_vector,
    output logic [LVL_W-1:0]     req_level,
    output logic [LVL_W-1:0]     run_level,
    output logic                 halt,
    output logic [NUM_SRC-1:0]   pend_flags
);
    typedef struct packed {
        logic [NUM_TRAP-1:0] flags;
    } trap_t;

    trap_t trap_d, trap_q;

    logic [NUM_SRC-1:0]             src_en;
    logic [NUM_SRC-1:0][PRIO_W-1:0] src_prio;
    logic [NUM_VEC-1:0]             cand_valid;
    logic [NUM_VEC-1:0][LVL_W-1:0]  cand_level;
    logic                           win_valid;
    logic [VEC_W-1:0]               win_vec;
    logic [LVL_W-1:0]               win_level;
    logic                           take;
    logic [CNT_W-1:0]               stk_cnt;

    irqc_src_bank #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (src_evt),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_enable (cfg_enable),
        .cfg_prio   (cfg_prio),
        .clr_we     (clr_we),
        .clr_idx    (clr_idx),
        .pend       (pend_flags),
        .enable     (src_en),
        .prio       (src_prio)
    );

    // Candidate list: traps occupy the low vectors, sources follow.
    for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap_cand
        assign cand_valid[t] = trap_q.flags[t];
        assign cand_level[t] = trap_level(t);
    end
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_cand
        assign cand_valid[NUM_TRAP+s] = pend_flags[s] && src_en[s] && (src_prio[s] != '0);
        assign cand_level[NUM_TRAP+s] = LVL_W'(src_prio[s]);
    end

    irqc_arbiter #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_arb (
        .cand_valid (cand_valid),
        .cand_level (cand_level),
        .win_valid  (win_valid),
        .win_vec    (win_vec),
        .win_level  (win_level)
    );

    assign req_valid  = win_valid && (win_level > run_level);
    assign req_vector = win_vec;
    assign req_level  = win_level;
    assign take       = ack && req_valid && !ret;

    irqc_level_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .new_level (win_level),
        .pop       (ret),
        .run_level (run_level),
        .count     (stk_cnt)
    );

    always_comb begin
        trap_d = trap_q;
        for (int t = 0; t < NUM_TRAP; t++) begin
            if (take && win_vec == VEC_W'(t)) begin
                trap_d.flags[t] = 1'b0;
            end
        end
        trap_d.flags = trap_d.flags | trap_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_q <= '0;
        end else begin
            trap_q <= trap_d;
        end
    end

    assign halt = |trap_q.flags[NUM_HARD-1:0];
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int STACK_DEPTH = 16,
    localparam int CNT_W = $clog2(STACK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] pend_flags,
    input logic               ack,
    input logic               ret,
    input logic               req_valid,
    input logic [LVL_W-1:0]   req_level,
    input logic [LVL_W-1:0]   run_level,
    input logic [CNT_W-1:0]   stk_cnt
);
    assert_evt_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((pend_flags & $past(src_evt)) == $past(src_evt)));

    assert_above_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_level > run_level));

    assert_ack_raise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid && !ret) |=> (run_level == $past(req_level)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_valid && !ret) |=> (stk_cnt == $past(stk_cnt) + 1'b1));

    assert_empty_base_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_cnt == '0) |-> (run_level == '0));

    assert_empty_ret_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && stk_cnt == '0) |=> $stable(run_level));
endmodule

bind prio_irq_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_evt    (src_evt),
    .pend_flags (pend_flags),
    .ack        (ack),
    .ret        (ret),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .run_level  (run_level),
    .stk_cnt    (stk_cnt)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_evt = '0;
    logic [4:0] trap_evt = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic       cfg_enable = 1'b0;
    logic [2:0] cfg_prio = '0;
    logic       clr_we = 1'b0;
    logic [2:0] clr_idx = '0;
    logic       ack = 1'b0;
    logic       ret = 1'b0;
    logic       req_valid;
    logic [3:0] req_vector;
    logic [3:0] req_level;
    logic [3:0] run_level;
    logic       halt;
    logic [7:0] pend_flags;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .trap_evt(trap_evt),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable), .cfg_prio(cfg_prio),
        .clr_we(clr_we), .clr_idx(clr_idx), .ack(ack), .ret(ret),
        .req_valid(req_valid), .req_vector(req_vector), .req_level(req_level),
        .run_level(run_level), .halt(halt), .pend_flags(pend_flags)
    );

    // Fields: {enable[8], prio[24] (source i in bits 3i+2:3i), pend[8], exp_valid, exp_vec[4], exp_lvl[4]}
    localparam logic [48:0] TBL [6] = '{
        {8'hFF, 24'h000000, 8'h01, 1'b0, 4'd0,  4'd0},
        {8'hFF, 24'h000A00, 8'h08, 1'b1, 4'd8,  4'd5},
        {8'h00, 24'h000A00, 8'h08, 1'b0, 4'd0,  4'd0},
        {8'hFF, 24'h100100, 8'h44, 1'b1, 4'd7,  4'd4},
        {8'hFF, 24'hC00010, 8'h82, 1'b1, 4'd12, 4'd6},
        {8'h20, 24'h038007, 8'h21, 1'b1, 4'd10, 4'd7}
    };
    string tags [6] = '{"R3", "R4", "R2", "R5", "R4", "R5"};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input int idx, input logic en, input logic [2:0] p);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_enable = en; cfg_prio = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_src(input logic [7:0] m);
        src_evt = m;
        @(negedge clk);
        src_evt = '0;
    endtask

    task automatic pulse_trap(input logic [4:0] m);
        trap_evt = m;
        @(negedge clk);
        trap_evt = '0;
    endtask

    task automatic clear(input int idx);
        clr_we = 1'b1; clr_idx = 3'(idx);
        @(negedge clk);
        clr_we = 1'b0;
    endtask

    task automatic strobe(input logic a, input logic r);
        ack = a; ret = r;
        @(negedge clk);
        ack = 1'b0; ret = 1'b0;
    endtask

    task automatic expect_req(input string tag, input int v, input int vec, input int lvl);
        chk({tag, " req_valid"}, int'(req_valid), v);
        if (v != 0) begin
            chk({tag, " req_vector"}, int'(req_vector), vec);
            chk({tag, " req_level"}, int'(req_level), lvl);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk("R1 req_valid", int'(req_valid), 0);
        chk("R1 run_level", int'(run_level), 0);
        chk("R1 halt", int'(halt), 0);
        chk("R1 pend_flags", int'(pend_flags), 0);
        pulse_src(8'hFF);
        chk("R1 masked after reset", int'(req_valid), 0);

        // Vector table walk
        for (int e = 0; e < 6; e++) begin
            do_reset();
            for (int i = 0; i < 8; i++) begin
                cfg(i, TBL[e][41+i], TBL[e][17+3*i +: 3]);
            end
            pulse_src(TBL[e][16:9]);
            chk({tags[e], " pend_flags"}, int'(pend_flags), int'(TBL[e][16:9]));
            expect_req(tags[e], int'(TBL[e][8]), int'(TBL[e][7:4]), int'(TBL[e][3:0]));
        end

        // R2, R7, R6: flag set while disabled, event beats clear, clear works
        do_reset();
        cfg(4, 1'b0, 3'd3);
        pulse_src(8'h10);
        chk("R2 flag while disabled", int'(pend_flags), 8'h10);
        chk("R2 no request when disabled", int'(req_valid), 0);
        src_evt = 8'h10; clr_we = 1'b1; clr_idx = 3'd4;
        @(negedge clk);
        src_evt = '0; clr_we = 1'b0;
        chk("R7 event beats clear", int'(pend_flags), 8'h10);
        clear(4);
        chk("R6 software clear", int'(pend_flags), 0);

        // R10, R12, R11, R6: nesting and unwinding
        do_reset();
        cfg(1, 1'b1, 3'd3);
        pulse_src(8'h02);
        expect_req("R4 first", 1, 6, 3);
        strobe(1'b1, 1'b0);
        chk("R10 run raised", int'(run_level), 3);
        chk("R4 equal level not requested", int'(req_valid), 0);
        chk("R6 flag kept after ack", int'(pend_flags), 8'h02);
        cfg(2, 1'b1, 3'd5);
        pulse_src(8'h04);
        expect_req("R12 preempt", 1, 7, 5);
        strobe(1'b1, 1'b0);
        chk("R12 nested run", int'(run_level), 5);
        strobe(1'b0, 1'b1);
        chk("R11 pop to 3", int'(run_level), 3);
        expect_req("R6 retaken above 3", 1, 7, 5);
        strobe(1'b0, 1'b1);
        chk("R11 pop to 0", int'(run_level), 0);
        clear(2);
        expect_req("R6 lower source again", 1, 6, 3);
        strobe(1'b0, 1'b1);
        chk("R11 ret on empty", int'(run_level), 0);
        strobe(1'b1, 1'b1);
        chk("R11 ret beats ack", int'(run_level), 0);
        expect_req("R11 request kept", 1, 6, 3);

        // R8, R9: traps
        pulse_trap(5'b00100);
        expect_req("R8 stack trap", 1, 2, 12);
        chk("R9 soft trap no halt", int'(halt), 0);
        strobe(1'b1, 1'b0);
        chk("R8 run at trap level", int'(run_level), 12);
        chk("R8 trap flag cleared", int'(req_valid), 0);
        pulse_trap(5'b00001);
        chk("R9 hard trap halt", int'(halt), 1);
        expect_req("R8 osc trap", 1, 0, 14);
        strobe(1'b1, 1'b0);
        chk("R9 halt drops on ack", int'(halt), 0);
        chk("R8 run at 14", int'(run_level), 14);

        do_reset();
        pulse_trap(5'b10000);
        expect_req("R8 unmaskable dma trap", 1, 4, 10);
        pulse_trap(5'b01010);
        expect_req("R8 address trap wins", 1, 1, 13);
        chk("R9 address trap halt", int'(halt), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule